// File: doc/BRIEF.md
# Branch and Jump Next-Address Unit

This block owns the 32-bit program counter of a simple load-store processor and chooses its next value on every advancing clock. Four kinds of control flow are supported: plain sequential stepping, a conditional branch relative to the address of the following instruction, an absolute jump within the current 256 MB region, and a jump through a full register value. The decoded opcode and function code, the 16-bit branch displacement, the 26-bit jump index and two register operands arrive from the decode stage. The block produces the registered program counter.

For the call form of the absolute jump, the block also presents the return address together with a one-cycle write request for link register 31. It flags a register-indirect target that is not word aligned. Instruction memory, the register file and any delay-slot handling sit outside this block.

Top module: `pc_steer`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o` takes the value of parameter RESET_VEC (default 0x0000_1000) at that edge.
- R2: When `adv_en` is low at a rising edge, `pc_o` keeps its value and `link_we` is low, whatever the other inputs are.
- R3: Any opcode other than 2, 3, 4 or 5, and other than opcode 0 with function code 8, advances `pc_o` by 4 modulo 2^32. This includes opcode 0 with any other function code.
- R4: Opcode 4 (branch on equal) loads `pc_o + 4 + (sign-extended br_disp shifted left by 2)` when `opnd_a == opnd_b`, and loads `pc_o + 4` otherwise.
- R5: Opcode 5 (branch on not equal) loads the same branch target when `opnd_a != opnd_b`, and loads `pc_o + 4` otherwise.
- R6: Opcode 2 (jump) loads `{(pc_o+4)[31:28], jmp_index, 2'b00}`.
- R7: Opcode 3 (jump and link) loads the same target as R6. In the same cycle `link_we` is high and `link_addr` equals `pc_o + 4`.
- R8: Opcode 0 with function code 8 (register jump) loads `opnd_a` unchanged into `pc_o`.
- R9: `fetch_misalign` is high, combinationally, exactly when opcode 0 with function code 8 is presented and `opnd_a[1:0]` is not zero.
- R10: `link_we` is low for every opcode other than 3. `link_addr` always shows `pc_o + 4`.
- R11: The increment wraps from 0xFFFF_FFFC to 0. The jump region bits are taken from `pc_o + 4`, so a jump from 0x0FFF_FFFC lands in region 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Advance the program counter at this edge |
| opc | input | 6 | Primary opcode of the current instruction |
| func_code | input | 6 | Function code, used when opc is 0 |
| br_disp | input | 16 | Signed branch displacement in words |
| jmp_index | input | 26 | Absolute jump word index |
| opnd_a | input | 32 | First compared operand; register-jump target |
| opnd_b | input | 32 | Second compared operand |
| pc_o | output | 32 | Registered program counter |
| link_we | output | 1 | Write request for link register 31 |
| link_addr | output | 32 | Return address, pc_o + 4 |
| fetch_misalign | output | 1 | Register-jump target not word aligned |

## Verification
`link_we`, `link_addr` and `fetch_misalign` depend only on the current inputs and `pc_o`. They are due in the same cycle as the stimulus, so the bench samples them 1 ns after driving the inputs at the falling edge. The new `pc_o` is due one rising edge later, and the bench samples it 1 ns after that edge against a model that applies R3 to R8 arithmetically. Each test first steers the counter to a chosen base with a register jump. The sweep then covers all 64 opcodes, three function codes, five displacements and equal and unequal operands from four base addresses, including the two wrap points.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
  localparam logic [OPC_W-1:0] OPC_JMP  = 6'd2;
  localparam logic [OPC_W-1:0] OPC_CALL = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BNE  = 6'd5;
  localparam logic [FN_W-1:0]  FN_RJMP  = 6'd8;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BEQ,
    FLOW_BNE,
    FLOW_JMP,
    FLOW_CALL,
    FLOW_RJMP
  } flow_e;
endpackage

// File: rtl/pc_flow_decode.sv
module pc_flow_decode
  import pc_steer_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [FN_W-1:0]  func_code,
  output flow_e            flow
);
  always_comb begin
    unique case (opc)
      OPC_JMP:  flow = FLOW_JMP;
      OPC_CALL: flow = FLOW_CALL;
      OPC_BEQ:  flow = FLOW_BEQ;
      OPC_BNE:  flow = FLOW_BNE;
      OPC_REG:  flow = (func_code == FN_RJMP) ? FLOW_RJMP : FLOW_SEQ;
      default:  flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/pc_branch_eval.sv
module pc_branch_eval
  import pc_steer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  flow_e             flow,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              taken
);
  logic same;

  assign same = (opnd_a == opnd_b);

  always_comb begin
    case (flow)
      FLOW_BEQ: taken = same;
      FLOW_BNE: taken = !same;
      default:  taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/pc_target_gen.sv
module pc_target_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int IDX_W  = 26
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  br_disp,
  input  logic [IDX_W-1:0]  jmp_index,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] br_addr,
  output logic [ADDR_W-1:0] jmp_addr
);
  localparam int EXT_W = ADDR_W - OFF_W - 2;
  localparam int REG_W = ADDR_W - IDX_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] disp_bytes;

  assign seq_addr   = pc + STEP;
  assign disp_bytes = {{EXT_W{br_disp[OFF_W-1]}}, br_disp, 2'b00};
  assign br_addr    = seq_addr + disp_bytes;
  assign jmp_addr   = {seq_addr[ADDR_W-1 -: REG_W], jmp_index, 2'b00};
endmodule

// File: rtl/pc_steer.sv
module pc_steer
  import pc_steer_pkg::*;
#(
  parameter int                 ADDR_W    = 32,
  parameter int                 OFF_W     = 16,
  parameter int                 IDX_W     = 26,
  parameter logic [ADDR_W-1:0]  RESET_VEC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  logic [5:0]        opc,
  input  logic [5:0]        func_code,
  input  logic [OFF_W-1:0]  br_disp,
  input  logic [IDX_W-1:0]  jmp_index,
  input  logic [ADDR_W-1:0] opnd_a,
  input  logic [ADDR_W-1:0] opnd_b,
  output logic [ADDR_W-1:0] pc_o,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_addr,
  output logic              fetch_misalign
);
  flow_e             flow;
  logic              taken;
  logic [ADDR_W-1:0] seq_addr, br_addr, jmp_addr, next_pc;

  pc_flow_decode u_dec (
    .opc       (opc),
    .func_code (func_code),
    .flow      (flow)
  );

  pc_branch_eval #(.DATA_W(ADDR_W)) u_cmp (
    .flow   (flow),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .taken  (taken)
  );

  pc_target_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
    .pc        (pc_o),
    .br_disp   (br_disp),
    .jmp_index (jmp_index),
    .seq_addr  (seq_addr),
    .br_addr   (br_addr),
    .jmp_addr  (jmp_addr)
  );

  always_comb begin
    case (flow)
      FLOW_BEQ, FLOW_BNE: next_pc = taken ? br_addr : seq_addr;
      FLOW_JMP, FLOW_CALL: next_pc = jmp_addr;
      FLOW_RJMP: next_pc = opnd_a;
      default: next_pc = seq_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o <= RESET_VEC;
    end else if (adv_en) begin
      pc_o <= next_pc;
    end
  end

  assign link_we        = adv_en && (flow == FLOW_CALL);
  assign link_addr      = seq_addr;
  assign fetch_misalign = (flow == FLOW_RJMP) && (opnd_a[1:0] != 2'b00);

  AST_RESET_VEC: assert property (@(posedge clk) rst |=> pc_o == RESET_VEC); // R1
  AST_HOLD_PC: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(pc_o)); // R2
  AST_NO_LINK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !adv_en |-> !link_we); // R2
  AST_RJMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (adv_en && opc == 6'd0 && func_code == 6'd8) |=> pc_o == $past(opnd_a)); // R8
  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (rst)
    link_we |=> pc_o == {$past(link_addr[ADDR_W-1 -: ADDR_W-IDX_W-2]), $past(jmp_index), 2'b00}); // R7
  AST_LINK_RET: assert property (@(posedge clk) disable iff (rst)
    link_we |=> $past(link_addr) == $past(pc_o) + ADDR_W'(4)); // R7
  AST_BNE_FALL: assert property (@(posedge clk) disable iff (rst)
    (adv_en && opc == 6'd5 && opnd_a == opnd_b) |=> pc_o == $past(pc_o) + ADDR_W'(4)); // R5
  AST_MISALIGN_SRC: assert property (@(posedge clk) disable iff (rst)
    fetch_misalign |-> (opnd_a[1:0] != 2'b00 && opc == 6'd0)); // R9
endmodule

// File: tb/pc_steer_tb.sv
module pc_steer_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        adv_en;
  logic [5:0]  opc, func_code;
  logic [15:0] br_disp;
  logic [25:0] jmp_index;
  logic [31:0] opnd_a, opnd_b;
  logic [31:0] pc_o, link_addr;
  logic        link_we, fetch_misalign;

  int checks = 0;
  int errors = 0;
  logic [31:0] pc_model;
  bit done = 0;

  always #4 clk = ~clk;

  pc_steer u_dut (
    .clk(clk), .rst(rst), .adv_en(adv_en), .opc(opc), .func_code(func_code),
    .br_disp(br_disp), .jmp_index(jmp_index), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .pc_o(pc_o), .link_we(link_we), .link_addr(link_addr),
    .fetch_misalign(fetch_misalign)
  );

  function automatic logic [31:0] model_next(input logic [31:0] pc, input logic en,
      input logic [5:0] op, input logic [5:0] fn, input logic [15:0] d,
      input logic [25:0] ix, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] p4;
    logic [31:0] bt;
    p4 = pc + 32'd4;
    bt = p4 + {{14{d[15]}}, d, 2'b00};
    if (!en) return pc;
    case (op)
      6'd0: return (fn == 6'd8) ? a : p4;
      6'd2, 6'd3: return {p4[31:28], ix, 2'b00};
      6'd4: return (a == b) ? bt : p4;
      6'd5: return (a != b) ? bt : p4;
      default: return p4;
    endcase
  endfunction

  function automatic string tag_of(input logic en, input logic [5:0] op, input logic [5:0] fn);
    if (!en) return "R2";
    case (op)
      6'd0: return (fn == 6'd8) ? "R8" : "R3";
      6'd2: return "R6";
      6'd3: return "R7";
      6'd4: return "R4";
      6'd5: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [5:0] op, input logic [5:0] fn,
      input logic [15:0] d, input logic [25:0] ix, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp;
    @(negedge clk);
    adv_en = en; opc = op; func_code = fn; br_disp = d; jmp_index = ix;
    opnd_a = a; opnd_b = b;
    #1;
    check32((en && op == 6'd3) ? "R7" : "R10", {31'd0, link_we}, {31'd0, en && op == 6'd3});
    check32("R10", link_addr, pc_model + 32'd4);
    check32("R9", {31'd0, fetch_misalign}, {31'd0, op == 6'd0 && fn == 6'd8 && a[1:0] != 2'b00});
    exp = model_next(pc_model, en, op, fn, d, ix, a, b);
    @(posedge clk);
    #1;
    check32(tag_of(en, op, fn), pc_o, exp);
    pc_model = exp;
  endtask

  task automatic set_pc(input logic [31:0] v);
    step(1'b1, 6'd0, 6'd8, 16'd0, 26'd0, v, 32'd0);
  endtask

  initial begin
    logic [31:0] bases [4];
    logic [15:0] disps [5];
    logic [5:0]  fns [3];
    bases = '{32'h0000_1000, 32'h0FFF_FFFC, 32'hFFFF_FFFC, 32'h8000_0000};
    disps = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000};
    fns   = '{6'd8, 6'd0, 6'd9};
    rst = 1'b1; adv_en = 1'b0; opc = 0; func_code = 0; br_disp = 0;
    jmp_index = 0; opnd_a = 0; opnd_b = 0;
    repeat (3) @(posedge clk);
    #1;
    check32("R1", pc_o, 32'h0000_1000);
    @(negedge clk);
    rst = 1'b0;
    pc_model = 32'h0000_1000;

    // R2: hold with a call and with a register jump presented
    step(1'b0, 6'd3, 6'd0, 16'd0, 26'h155_5555, 32'd0, 32'd0);
    step(1'b0, 6'd0, 6'd8, 16'd0, 26'd0, 32'h1234_5678, 32'd0);

    // R11: wrap points
    set_pc(32'hFFFF_FFFC);
    step(1'b1, 6'd9, 6'd0, 16'd0, 26'd0, 32'd0, 32'd0);
    check32("R11", pc_o, 32'h0000_0000);
    set_pc(32'h0FFF_FFFC);
    step(1'b1, 6'd2, 6'd0, 16'd0, 26'd5, 32'd0, 32'd0);
    check32("R11", pc_o, 32'h1000_0014);

    // R9: misaligned register jump target is still loaded
    step(1'b1, 6'd0, 6'd8, 16'd0, 26'd0, 32'h0000_2002, 32'd0);
    step(1'b1, 6'd1, 6'd0, 16'd0, 26'd0, 32'd0, 32'd0);

    // sweep R3..R8
    foreach (bases[bi]) begin
      for (int op = 0; op < 64; op++) begin
        foreach (fns[fi]) begin
          foreach (disps[di]) begin
            for (int eq = 0; eq < 2; eq++) begin
              set_pc(bases[bi]);
              step(1'b1, 6'(op), fns[fi], disps[di], 26'h2AA_AAAA ^ 26'(di),
                   32'hA5A5_0004 + 32'(fi), (eq != 0) ? 32'hA5A5_0004 + 32'(fi) : 32'h5A5A_0000);
            end
          end
        end
      end
    end

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check32("R1", pc_o, 32'h0000_1000);
    @(negedge clk);
    rst = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule